// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that a memory controller puts on the bus, one address per accepted beat. A request carries a starting column and a read/write flag. It is taken together with three plain configuration pins: a length code, an order select and a single-write mode. All of these are captured in the cycle the request is accepted. The block then streams addresses until the burst ends.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that size. Sequential order counts the low bits upward and wraps. Interleaved order XORs the low bits of the start with the beat index. A full-page burst walks the whole 512-column page with wrap-around and runs until the stop input ends it. A stop input can also cut any burst short.

Requests use a valid/ready handshake. The address stream is valid/ready too. A beat advances only when `out_valid` and `out_ready` are both high, and while `out_ready` is low the address and flags are held. `req_ready` is high when the block is idle, or during the cycle the last beat is handed over. The first beat of the next burst therefore follows with no gap. `req_ready` depends combinationally on `out_ready` and `stop`.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and right after it, `out_valid` and `out_last` are 0 and `req_ready` is 1.
- R2: Length code 0, 1, 2 or 3 gives a burst of 1, 2, 4 or 8 beats. Any code of 4 to 7 selects a full-page burst.
- R3: In sequential order with length N of 2, 4 or 8, beat k carries the start column with its low log2(N) bits replaced by (start + k) mod N. The upper bits equal those of the start.
- R4: In interleaved order with length N of 2, 4 or 8 (`cfg_interleave`=1), beat k carries the start column with its low log2(N) bits replaced by (start XOR k).
- R5: A full-page burst emits (start + k) mod 512 on beat k and continues until stopped. The order select has no effect on it.
- R6: `out_last` is 1 with the final beat of a fixed-length burst. After the final beat is accepted, `out_valid` falls unless a new request was taken.
- R7: When `stop` is 1 while a beat is valid, that beat is marked last and the burst ends once it is accepted. This applies to any length.
- R8: With `cfg_single_write`=1, a request with `req_write`=1 yields one beat at the start column whatever the length code. Reads keep the programmed length. With the mode off, writes keep the programmed length.
- R9: While `out_valid` is 1 and `out_ready` is 0, the column and flags hold. `req_ready` is 0 during a burst, except in a cycle where the last beat is accepted.
- R10: A request accepted in the same cycle as the last beat puts its first beat on the outputs in the next cycle, with no idle cycle.
- R11: The request fields and configuration pins are used only at acceptance. Changing them during a burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_code | input | 3 | Burst length code (R2) |
| cfg_interleave | input | 1 | 1 selects interleaved order |
| cfg_single_write | input | 1 | 1 makes every write a single beat |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request can be accepted |
| req_col | input | 9 | Starting column |
| req_write | input | 1 | 1 for a write request |
| stop | input | 1 | Ends the burst at the current beat |
| out_valid | output | 1 | Column output valid |
| out_ready | input | 1 | Consumer takes the current beat |
| out_col | output | 9 | Column address of the current beat |
| out_last | output | 1 | Current beat is the last of the burst |

## Verification
The assertions assume that `stop` is only meaningful while a beat is valid, and that `out_ready` may drop in any cycle. They check holding, beat stepping and the upper-bit fence against those rules. The stimulus raises `stop` only at a chosen beat and keeps it high until that beat is taken. It drives `out_ready` from a random ready rate. Outside the acceptance cycle it scrambles every request and configuration pin, so any late sampling would show up as a wrong column.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int LEN_CODE_W = 3;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int COL_W       = 9,
  parameter int FIX_LOG_MAX = 3
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  interleave,
  input  logic                  single_wr_mode,
  input  logic                  is_write,
  output logic [COL_W-1:0]      mask,
  output logic                  full_page,
  output burst_order_e          order
);
  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  logic one_beat;
  logic code_full;

  always_comb begin
    one_beat  = single_wr_mode && is_write;
    code_full = (len_code > LEN_CODE_W'(FIX_LOG_MAX));
    if (one_beat) begin
      mask      = '0;
      full_page = 1'b0;
    end else if (code_full) begin
      mask      = PAGE_MASK;
      full_page = 1'b1;
    end else begin
      mask      = (COL_W'(1) << len_code) - COL_W'(1);
      full_page = 1'b0;
    end
    order = (interleave && !full_page) ? ORD_ILV : ORD_SEQ;
  end
endmodule

// File: rtl/colgen_seq_ctrl.sv
module colgen_seq_ctrl
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [COL_W-1:0] req_col,
  input  logic [COL_W-1:0] dec_mask,
  input  logic             dec_full,
  input  burst_order_e     dec_order,
  input  logic             stop,
  input  logic             out_ready,
  output logic             beat_valid,
  output logic             beat_last,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] cnt_q,
  output logic [COL_W-1:0] mask_q,
  output burst_order_e     order_q
);
  logic busy_q;
  logic full_q;
  logic accept;
  logic handshake;
  logic final_beat;

  always_comb begin
    final_beat = !full_q && (cnt_q == mask_q);
    beat_valid = busy_q;
    beat_last  = busy_q && (final_beat || stop);
    handshake  = busy_q && out_ready;
    req_ready  = !busy_q || (handshake && beat_last);
    accept     = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      full_q  <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      order_q <= ORD_SEQ;
    end else if (accept) begin
      busy_q  <= 1'b1;
      full_q  <= dec_full;
      base_q  <= req_col;
      cnt_q   <= '0;
      mask_q  <= dec_mask;
      order_q <= dec_order;
    end else if (handshake && beat_last) begin
      busy_q <= 1'b0;
    end else if (handshake) begin
      cnt_q <= cnt_q + COL_W'(1);
    end
  end

  // R3: the beat counter never leaves the window picked at acceptance
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((cnt_q & ~mask_q) == '0));

  // R10: an accepted request is on the outputs in the next cycle
  p_accept_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (beat_valid && cnt_q == '0));

  // R9: a burst in flight blocks new requests unless it is ending
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(out_ready && beat_last)) |-> !req_ready);
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter bit ILV_EN = 1'b1
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  burst_order_e     order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] low;

  assign seq_low = (base + cnt) & mask;

  generate
    if (ILV_EN) begin : g_ilv
      logic [COL_W-1:0] ilv_low;
      assign ilv_low = (base ^ cnt) & mask;
      assign low     = (order == ORD_ILV) ? ilv_low : seq_low;
    end else begin : g_seq_only
      assign low = seq_low;
    end
  endgenerate

  assign col = (base & ~mask) | low;
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W       = 9,
  parameter int FIX_LOG_MAX = 3,
  parameter bit ILV_EN      = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_CODE_W-1:0] cfg_len_code,
  input  logic                  cfg_interleave,
  input  logic                  cfg_single_write,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [COL_W-1:0]      req_col,
  input  logic                  req_write,
  input  logic                  stop,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [COL_W-1:0]      out_col,
  output logic                  out_last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  burst_order_e     dec_order;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] mask_q;
  burst_order_e     order_q;

  colgen_len_decode #(.COL_W(COL_W), .FIX_LOG_MAX(FIX_LOG_MAX)) i_dec (
    .len_code      (cfg_len_code),
    .interleave    (cfg_interleave),
    .single_wr_mode(cfg_single_write),
    .is_write      (req_write),
    .mask          (dec_mask),
    .full_page     (dec_full),
    .order         (dec_order)
  );

  colgen_seq_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_col   (req_col),
    .dec_mask  (dec_mask),
    .dec_full  (dec_full),
    .dec_order (dec_order),
    .stop      (stop),
    .out_ready (out_ready),
    .beat_valid(out_valid),
    .beat_last (out_last),
    .base_q    (base_q),
    .cnt_q     (cnt_q),
    .mask_q    (mask_q),
    .order_q   (order_q)
  );

  colgen_addr_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) i_map (
    .base (base_q),
    .cnt  (cnt_q),
    .mask (mask_q),
    .order(order_q),
    .col  (out_col)
  );

  // R6: the last flag only accompanies a valid beat
  p_last_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9: a stalled beat keeps its column
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_col)));

  // R3: bits above the window stay put from beat to beat
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && (((out_col ^ $past(out_col)) & ~mask_q) == '0)));

  // R5: sequential beats step by one inside the window
  p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last && order_q == ORD_SEQ) |=>
      (((out_col - $past(out_col)) & mask_q) == COL_W'(1)));
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_len_code = '0;
  logic       cfg_interleave = 1'b0;
  logic       cfg_single_write = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [8:0] req_col = '0;
  logic       req_write = 1'b0;
  logic       stop = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [8:0] out_col;
  logic       out_last;

  int total = 0;
  int bad = 0;

  logic [8:0] n_st;
  logic [2:0] n_code;
  bit         n_ilv, n_sw, n_wr;

  always #2 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cfg_len_code(cfg_len_code),
    .cfg_interleave(cfg_interleave), .cfg_single_write(cfg_single_write),
    .req_valid(req_valid), .req_ready(req_ready), .req_col(req_col),
    .req_write(req_write), .stop(stop), .out_valid(out_valid),
    .out_ready(out_ready), .out_col(out_col), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] emask(input logic [2:0] code, input bit sw, input bit wr);
    if (sw && wr) return 9'd0;
    if (code >= 3'd4) return 9'h1FF;
    return (9'd1 << code) - 9'd1;
  endfunction

  function automatic bit efull(input logic [2:0] code, input bit sw, input bit wr);
    return !(sw && wr) && (code >= 3'd4);
  endfunction

  function automatic logic [8:0] ecol(input logic [8:0] st, input logic [2:0] code,
                                      input bit ilv, input bit sw, input bit wr, input int k);
    logic [8:0] m;
    logic [8:0] lo;
    m = emask(code, sw, wr);
    if (ilv && !efull(code, sw, wr)) lo = (st ^ 9'(k)) & m;
    else lo = (st + 9'(k)) & m;
    return (st & ~m) | lo;
  endfunction

  task automatic run_burst(input logic [8:0] st, input logic [2:0] code, input bit ilv,
                           input bit sw, input bit wr, input int stop_at, input int rdy_pct,
                           input bit pre_acc, input bit chain);
    int k = 0;
    bit done = 0;
    bit elast;
    logic [8:0] m;
    string ctag;
    m = emask(code, sw, wr);
    if (sw && wr) ctag = "R8 column";
    else if (efull(code, sw, wr)) ctag = "R5 column";
    else if (ilv) ctag = "R4 column";
    else ctag = "R3 column";
    if (!pre_acc) begin
      @(negedge clk);
      cfg_len_code = code; cfg_interleave = ilv; cfg_single_write = sw;
      req_col = st; req_write = wr; req_valid = 1'b1; out_ready = 1'b0; stop = 1'b0;
      #1;
      chk(req_ready == 1'b1, "R9 idle req_ready", int'(req_ready), 1);
    end
    while (!done) begin
      @(negedge clk);
      req_valid = 1'b0;
      // R11: scramble every sampled input while the burst runs
      cfg_len_code = 3'($urandom); cfg_interleave = 1'($urandom);
      cfg_single_write = 1'($urandom); req_col = 9'($urandom); req_write = 1'($urandom);
      out_ready = (($urandom % 100) < rdy_pct);
      stop = (k == stop_at);
      elast = (!efull(code, sw, wr) && k == int'(m)) || (k == stop_at);
      if (chain && elast) begin
        out_ready = 1'b1;
        n_st = 9'($urandom); n_code = 3'($urandom % 8);
        n_ilv = 1'($urandom); n_sw = 1'($urandom); n_wr = 1'($urandom);
        cfg_len_code = n_code; cfg_interleave = n_ilv; cfg_single_write = n_sw;
        req_col = n_st; req_write = n_wr; req_valid = 1'b1;
      end
      #1;
      if (pre_acc && k == 0) chk(out_valid == 1'b1, "R10 no idle cycle", int'(out_valid), 1);
      else chk(out_valid == 1'b1, "R9 valid in burst", int'(out_valid), 1);
      chk(out_col == ecol(st, code, ilv, sw, wr, k), ctag,
          int'(out_col), int'(ecol(st, code, ilv, sw, wr, k)));
      chk(out_last == elast, (k == stop_at) ? "R7 stop last" : "R6 last flag",
          int'(out_last), int'(elast));
      chk(req_ready == (out_ready && elast), "R9 req_ready", int'(req_ready),
          int'(out_ready && elast));
      if (out_ready) begin
        if (elast) done = 1;
        k++;
      end
    end
    if (!chain) begin
      @(negedge clk);
      req_valid = 1'b0; out_ready = 1'b0; stop = 1'b0;
      #1;
      chk(out_valid == 1'b0, "R6 burst ended", int'(out_valid), 0);
      chk(k == ((stop_at >= 0 && stop_at <= int'(m)) || efull(code, sw, wr) ? stop_at + 1 : int'(m) + 1),
          "R2 beat count", k,
          ((stop_at >= 0 && stop_at <= int'(m)) || efull(code, sw, wr)) ? stop_at + 1 : int'(m) + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit pend;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1 reset last", int'(out_last), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0 && req_ready == 1'b1, "R1 after reset", int'(out_valid), 0);

    // R2 / R3: each fixed length, sequential
    for (int c = 0; c < 4; c++) run_burst(9'h1AD, 3'(c), 0, 0, 0, -1, 100, 0, 0);
    // R4: interleaved lengths
    run_burst(9'h0D5, 3'd3, 1, 0, 0, -1, 100, 0, 0);
    run_burst(9'h0A6, 3'd2, 1, 0, 0, -1, 60, 0, 0);
    // R5: full page wraps past column 511; interleave ignored
    run_burst(9'h1F0, 3'd7, 0, 0, 0, 40, 100, 0, 0);
    run_burst(9'h1FE, 3'd4, 1, 0, 0, 5, 100, 0, 0);
    run_burst(9'h003, 3'd5, 0, 0, 0, 520, 100, 0, 0);
    // R8: single write mode
    run_burst(9'h137, 3'd3, 0, 1, 1, -1, 100, 0, 0);
    run_burst(9'h137, 3'd7, 1, 1, 1, -1, 100, 0, 0);
    run_burst(9'h137, 3'd2, 0, 1, 0, -1, 100, 0, 0);
    run_burst(9'h137, 3'd2, 0, 0, 1, -1, 100, 0, 0);
    // R7: stop truncates fixed bursts
    run_burst(9'h04C, 3'd3, 0, 0, 0, 2, 50, 0, 0);
    run_burst(9'h04C, 3'd0, 0, 0, 0, 0, 100, 0, 0);
    // R9: heavy back-pressure
    run_burst(9'h0F1, 3'd3, 1, 0, 0, -1, 20, 0, 0);
    // R10: back-to-back pair
    run_burst(9'h011, 3'd2, 0, 0, 0, -1, 100, 0, 1);
    run_burst(n_st, n_code, n_ilv, n_sw, n_wr, efull(n_code, n_sw, n_wr) ? 9 : -1, 100, 1, 0);

    // constrained random mix
    pend = 0;
    for (int i = 0; i < 200; i++) begin
      logic [8:0] st; logic [2:0] code; bit ilv, sw, wr, ch; int sa;
      if (pend) begin
        st = n_st; code = n_code; ilv = n_ilv; sw = n_sw; wr = n_wr;
      end else begin
        st = 9'($urandom); code = 3'($urandom % 8);
        ilv = 1'($urandom); sw = 1'($urandom); wr = 1'($urandom);
      end
      if (efull(code, sw, wr)) sa = int'($urandom % 50);
      else if ($urandom % 4 == 0) sa = int'($urandom % 8);
      else sa = -1;
      ch = ($urandom % 3 == 0) && (i < 199);
      run_burst(st, code, ilv, sw, wr, sa, 70, pend, ch);
      pend = ch;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule